// File: doc/BRIEF.md
# Serial ID Responder with Bus Timeout

This block is a two-wire serial bus target that answers to one fixed 7-bit address. It presents a nine-byte register window. Slots 0 to 7 hold a 64-bit identifier that is fixed at build time through a parameter. Slot 8 holds a control byte. A host first writes a byte pointer. It then reads bytes one after another, and the pointer advances and wraps at the end of the window. Because the address cannot be changed, only one such target can sit on a bus segment.

The block samples SCL and SDA with a fast system clock through two-stage synchronisers. It drives SDA only by pulling it low, through an output-enable. After each falling edge of SCL, it holds that enable steady for a set number of clock cycles. An idle-bus watchdog is armed by bit 0 of the control byte. If the watchdog finds the bus stuck, the block abandons the transfer as if a STOP had arrived. SCL rates from 100 kHz to 400 kHz are covered by choosing the system clock and the two cycle-count parameters.

Top module: `i2c_id_slave`

## Requirements
- R1: The block acknowledges only the address DEV_ADDR, in either direction. For any other address it leaves SDA released during the acknowledge bit and during every later bit, until the next START.
- R2: A read of pointer values 0 to 7 returns UID bits [8p+7:8p], so slot 0 holds the least significant byte. Pointer 8 returns the control byte: CM in bit 0 and zeros in bits 7:1. Each byte is sent most significant bit first.
- R3: The first data byte of a write transfer loads the pointer. A value above 8 loads 0.
- R4: Later data bytes in a write transfer are acknowledged. When the pointer is 8, bit 0 of such a byte is stored as CM. When the pointer is 0 to 7, the byte changes nothing, and the pointer does not move.
- R5: Each byte read advances the pointer, and the pointer wraps from 8 to 0. The pointer keeps its value from one transfer to the next.
- R6: A repeated START begins a new address phase and leaves the pointer unchanged.
- R7: CM is 1 after reset. While CM is 1, the block returns to idle and releases SDA if TIMEOUT_CYC cycles pass with no SCL edge and no SDA rising edge.
- R8: While CM is 0, a stalled bus never causes the block to release an acknowledge it is driving.
- R9: The SDA output-enable does not change during the HOLD_CYC cycles after the block detects a falling edge of SCL.
- R10: sda_oe is 0 while rst_n is low.
- R11: When the host does not acknowledge a read byte, the block releases SDA and sends no further data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | When 1, the pad pulls SDA low |

## Verification
The hardest state to reach from the ports is a bus stall while the block itself is holding SDA low. Only there does the watchdog decide between releasing the line and holding it. The bench reaches this state by clocking in the block's own address and then parking SCL low during the acknowledge bit. It does this once with CM cleared, expecting the line to stay low, and once with CM set, expecting the line to be released. After the release it runs a fresh transfer to show that the block has recovered.

// File: rtl/i2c_id_slave.sv
module i2c_id_slave #(
  parameter logic [6:0]  DEV_ADDR    = 7'h50,
  parameter logic [63:0] UID         = 64'h0123_4567_89AB_CDEF,
  parameter int          TIMEOUT_CYC = 6000000,
  parameter int          HOLD_CYC    = 60
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);

  localparam int TW = $clog2(TIMEOUT_CYC + 1);
  localparam int HW = $clog2(HOLD_CYC + 1);
  localparam logic [3:0] LAST = 4'd8;

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_AACK, S_WR, S_WACK, S_RD, S_RACK} st_t;

  logic [2:0] scl_p, sda_p;
  logic [TW-1:0] tcnt;
  logic [HW-1:0] hcnt;
  st_t st;
  logic [3:0] bitn, ptr;
  logic [7:0] sh;
  logic cm, rw, first, mnack, want;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_p <= '1;
      sda_p <= '1;
    end else begin
      scl_p <= {scl_p[1:0], scl_i};
      sda_p <= {sda_p[1:0], sda_i};
    end

  wire scl_rise = scl_p[1] & ~scl_p[2];
  wire scl_fall = ~scl_p[1] & scl_p[2];
  wire sda_rise = sda_p[1] & ~sda_p[2];
  wire start_c  = scl_p[1] & scl_p[2] & sda_p[2] & ~sda_p[1];
  wire stop_c   = scl_p[1] & scl_p[2] & ~sda_p[2] & sda_p[1];
  wire activity = scl_rise | scl_fall | sda_rise;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) tcnt <= '0;
    else if (activity) tcnt <= '0;
    else if (tcnt != TW'(TIMEOUT_CYC)) tcnt <= tcnt + TW'(1);

  wire tmo = cm & ~activity & (tcnt == TW'(TIMEOUT_CYC - 1));

  wire [7:0] rd_byte = (ptr == LAST) ? {7'b0, cm} : UID[{ptr[2:0], 3'b000} +: 8];
  wire [3:0] nxt = (ptr == LAST) ? 4'd0 : ptr + 4'd1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st    <= S_IDLE;
      bitn  <= '0;
      sh    <= '0;
      ptr   <= '0;
      cm    <= 1'b1;
      rw    <= 1'b0;
      first <= 1'b0;
      mnack <= 1'b0;
    end else if (start_c) begin
      st   <= S_ADDR;
      bitn <= '0;
    end else if (stop_c | tmo) begin
      st <= S_IDLE;
    end else begin
      case (st)
        S_ADDR, S_WR: begin
          if (scl_rise) begin
            sh   <= {sh[6:0], sda_p[1]};
            bitn <= bitn + 4'd1;
          end else if (scl_fall && bitn == LAST) begin
            bitn <= '0;
            if (st == S_ADDR) begin
              if (sh[7:1] == DEV_ADDR) begin
                st <= S_AACK;
                rw <= sh[0];
              end else st <= S_IDLE;
            end else begin
              if (first) ptr <= (sh > 8'd8) ? 4'd0 : sh[3:0];
              else if (ptr == LAST) cm <= sh[0];
              first <= 1'b0;
              st    <= S_WACK;
            end
          end
        end
        S_AACK: if (scl_fall) begin
          bitn <= '0;
          if (rw) begin
            sh  <= rd_byte;
            ptr <= nxt;
            st  <= S_RD;
          end else begin
            first <= 1'b1;
            st    <= S_WR;
          end
        end
        S_WACK: if (scl_fall) st <= S_WR;
        S_RD: if (scl_fall) begin
          if (bitn == 4'd7) st <= S_RACK;
          else begin
            sh   <= {sh[6:0], 1'b0};
            bitn <= bitn + 4'd1;
          end
        end
        S_RACK: begin
          if (scl_rise) mnack <= sda_p[1];
          else if (scl_fall) begin
            if (mnack) st <= S_IDLE;
            else begin
              sh   <= rd_byte;
              ptr  <= nxt;
              bitn <= '0;
              st   <= S_RD;
            end
          end
        end
        default: ;
      endcase
    end

  always_comb
    case (st)
      S_AACK, S_WACK: want = 1'b1;
      S_RD:           want = ~sh[7];
      default:        want = 1'b0;
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hcnt   <= '0;
      sda_oe <= 1'b0;
    end else if (scl_fall) hcnt <= HW'(HOLD_CYC);
    else if (hcnt != '0) hcnt <= hcnt - HW'(1);
    else sda_oe <= want;

endmodule

// File: rtl/i2c_id_slave_chk.sv
module i2c_id_slave_chk #(
  parameter int HOLD = 60
) (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_fall,
  input logic       tmo,
  input logic       sda_oe,
  input logic [2:0] st,
  input logic [3:0] ptr
);

  int c;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) c <= 0;
    else if (scl_fall) c <= 1;
    else if (c != 0) c <= (c == HOLD + 1) ? 0 : c + 1;

  always @(posedge clk)
    if (!rst_n) p_reset_quiet_r10: assert (!sda_oe);

  p_hold_window_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (c != 0) |-> $stable(sda_oe));

  p_timeout_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tmo |=> ##1 !sda_oe);

  p_drive_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> ($past(st) == 3'd2 || $past(st) == 3'd4 || $past(st) == 3'd5));

  p_ptr_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ptr <= 4'd8);

endmodule

bind i2c_id_slave i2c_id_slave_chk #(.HOLD(HOLD_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_fall(scl_fall), .tmo(tmo),
  .sda_oe(sda_oe), .st(st), .ptr(ptr)
);

// File: tb/sim_i2c_id_slave.sv
module sim_i2c_id_slave;
  localparam logic [6:0]  A   = 7'h50;
  localparam logic [63:0] ID  = 64'hC3A5_1E77_0F42_9B68;
  localparam int          TMO = 400;
  localparam int          HLD = 8;
  localparam int          Q   = 16;

  logic clk = 0, rst_n = 0, scl_m = 1, sda_m = 1;
  logic sda_oe;
  wire  sda_line = sda_m & ~sda_oe;
  int checks = 0, errors = 0, hold_err = 0, since = 100;
  int m_ptr = 0, m_cm = 1;
  logic scl_prev = 1, oe_prev = 0;
  logic [7:0] exp_q[$];

  always #2.5 clk = ~clk;

  i2c_id_slave #(.DEV_ADDR(A), .UID(ID), .TIMEOUT_CYC(TMO), .HOLD_CYC(HLD)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe));

  always @(negedge clk) begin
    if (scl_prev && !scl_m) since = 0;
    else if (since < 1000) since++;
    if (rst_n && sda_oe !== oe_prev && since < HLD) hold_err++;
    if (!rst_n && sda_oe !== 1'b0) hold_err++;
    scl_prev = scl_m;
    oe_prev  = sda_oe;
  end

  task automatic tick(input int n); repeat (n) @(negedge clk); endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] model_read();
    logic [7:0] b = (m_ptr == 8) ? {7'b0, m_cm[0]} : 8'(ID >> (8 * m_ptr));
    m_ptr = (m_ptr == 8) ? 0 : m_ptr + 1;
    return b;
  endfunction

  task automatic start_c();
    sda_m = 1; tick(Q); scl_m = 1; tick(Q); sda_m = 0; tick(Q); scl_m = 0; tick(Q);
  endtask
  task automatic stop_c();
    sda_m = 0; tick(Q); scl_m = 1; tick(Q); sda_m = 1; tick(Q);
  endtask
  task automatic bit_c(input logic b, output logic r);
    sda_m = b; tick(Q); scl_m = 1; tick(Q); r = sda_line; tick(Q); scl_m = 0; tick(Q);
  endtask
  task automatic send8(input logic [7:0] v);
    logic r;
    for (int i = 7; i >= 0; i--) bit_c(v[i], r);
  endtask
  task automatic wbyte(input logic [7:0] v, output logic ack);
    logic r;
    send8(v); bit_c(1'b1, r); ack = ~r;
  endtask
  task automatic rbyte(input logic give_ack, output logic [7:0] v);
    logic r;
    for (int i = 7; i >= 0; i--) begin bit_c(1'b1, r); v[i] = r; end
    bit_c(~give_ack, r);
  endtask

  task automatic wr(input logic [7:0] p, input int has_d, input logic [7:0] d, input string req);
    logic ack;
    start_c(); wbyte({A, 1'b0}, ack); chk({req, " addr ack"}, {7'b0, ack}, 8'd1);
    wbyte(p, ack); chk({req, " ptr ack"}, {7'b0, ack}, 8'd1);
    m_ptr = (p > 8) ? 0 : int'(p);
    if (has_d != 0) begin
      wbyte(d, ack); chk({req, " data ack"}, {7'b0, ack}, 8'd1);
      if (m_ptr == 8) m_cm = int'(d[0]);
    end
    stop_c();
  endtask

  task automatic rd(input int n, input string req);
    logic ack; logic [7:0] v;
    start_c(); wbyte({A, 1'b1}, ack); chk({req, " addr ack"}, {7'b0, ack}, 8'd1);
    for (int i = 0; i < n; i++) exp_q.push_back(model_read());
    for (int i = 0; i < n; i++) begin
      rbyte(i != n - 1, v);
      chk(req, v, exp_q.pop_front());
    end
    tick(Q); chk("R11 release after host nack", {7'b0, sda_oe}, 8'd0);
    stop_c();
  endtask

  initial begin
    logic ack; logic [7:0] v;
    tick(5); sda_m = 0; tick(3); scl_m = 0; tick(3);
    chk("R10 reset quiet", {7'b0, sda_oe}, 8'd0);
    scl_m = 1; sda_m = 1; tick(5);
    rst_n = 1; tick(20);

    start_c(); wbyte({7'h21, 1'b0}, ack); chk("R1 foreign addr nack", {7'b0, ack}, 8'd0);
    wbyte(8'h00, ack); chk("R1 silent after foreign addr", {7'b0, ack}, 8'd0);
    stop_c();

    wr(8'h00, 0, 8'h00, "R3");
    rd(10, "R2 R5 R7 map, cm reset, wrap");
    rd(1, "R5 pointer persists");
    wr(8'h03, 1, 8'hAA, "R4");
    rd(1, "R4 id write ignored");

    start_c(); wbyte({A, 1'b0}, ack); wbyte(8'h05, ack); m_ptr = 5;
    start_c(); wbyte({A, 1'b1}, ack); chk("R6 restart addr ack", {7'b0, ack}, 8'd1);
    rbyte(1'b1, v); chk("R6 restart read", v, model_read());
    rbyte(1'b0, v); chk("R6 restart read next", v, model_read());
    stop_c();

    wr(8'h2C, 0, 8'h00, "R3 out of range");
    rd(1, "R3 out of range reads slot0");
    wr(8'h08, 1, 8'hFE, "R4 clear cm");
    rd(1, "R4 cm cleared");

    start_c(); send8({A, 1'b0}); sda_m = 1; tick(3 * TMO);
    chk("R8 stall keeps ack", {7'b0, sda_oe}, 8'd1);
    tick(Q); scl_m = 1; tick(Q); scl_m = 0; tick(Q); stop_c();

    wr(8'h08, 1, 8'hFF, "R4 set cm");
    rd(1, "R2 control upper bits zero");

    start_c(); send8({A, 1'b0}); sda_m = 1; tick(Q);
    chk("R7 ack driven before stall", {7'b0, sda_oe}, 8'd1);
    tick(TMO + 50);
    chk("R7 timeout released ack", {7'b0, sda_oe}, 8'd0);
    stop_c();
    wr(8'h02, 0, 8'h00, "R7 recovery");
    rd(1, "R7 recovery read");

    checks++;
    if (hold_err != 0) begin
      errors++;
      $display("FAIL R9 hold/reset monitor actual %0d expected 0", hold_err);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule